// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte-Lane Writes

This block models the control and data path of a synchronous, pipelined burst static RAM. It holds a small on-chip word array with four byte lanes. All control inputs are sampled on the rising clock edge. Two address strobes can open an access: a processor-side strobe and a controller-side strobe. A burst-advance input steps an internal two-bit beat counter, and a set of write enables chooses which byte lanes of the current word are written.

An access starts when one of the strobes is low and all three chip-select inputs agree. The processor-side strobe only loads the address. No write happens in that cycle. The controller-side strobe loads the address and may write it in the same cycle. Later cycles without a strobe continue the burst. In each such cycle the beat counter either holds, so the same word is accessed again, or moves on to the next word of the aligned group of four. Any access that does not write is a read. Its data appears on the output one clock later and is flagged valid only while the output enable is low.

Top module: `sburst_sram`

## Requirements
- R1: The part counts as selected only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1. A controller strobe (`strobe_ctrl_n`=0) seen while not selected ends the burst. Cycles without a strobe then neither write nor read until a new selected strobe arrives.
- R2: With `all_wr_n`=0, a write cycle writes all four lanes, whatever `lane_wr_en_n` and `lane_n` are.
- R3: With `all_wr_n`=1, lane k (bits 8k+7:8k of the word) is written only when `lane_wr_en_n`=0 and `lane_n[k]`=0. All other lanes keep their old contents.
- R4: A selected processor strobe (`strobe_proc_n`=0, `strobe_ctrl_n`=1) loads `addr` and writes nothing, whatever the write enables are.
- R5: A selected controller strobe loads `addr`. In the same cycle it writes that word when `advance_n`=1. When `advance_n`=0 it writes nothing.
- R6: In a burst cycle without a strobe and with `advance_n`=0, the access goes to the next word. Address bits 1:0 count up by one and wrap from 3 to 0. The upper address bits stay as they were loaded.
- R7: In a burst cycle without a strobe and with `advance_n`=1, the counter holds, so a write repeats at the current word.
- R8: A non-writing access returns the word on `rdata` one clock later. `rvalid`=1 only when that holds and `oe_n`=0. Otherwise `rdata` is zero. The cycle after a write always has `rvalid`=0.
- R9: When both strobes are low in one cycle, the controller strobe's rules (R1, R5) apply.
- R10: A processor strobe seen while not selected has no effect. An open burst carries on as though no strobe were present.
- R11: After reset, `rvalid`=0, `rdata`=0 and no burst is open, so cycles without a strobe do not write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address loaded by a strobe |
| strobe_proc_n | input | 1 | Processor-side address strobe, active low |
| strobe_ctrl_n | input | 1 | Controller-side address strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b_n | input | 1 | Second chip select, active low |
| sel_c | input | 1 | Third chip select, active high |
| all_wr_n | input | 1 | Global write of every lane, active low |
| lane_wr_en_n | input | 1 | Enables per-lane writes, active low |
| lane_n | input | LANES | Per-lane write strobes, active low |
| oe_n | input | 1 | Output enable, active low |
| wdata | input | LANES*8 | Write data |
| rdata | output | LANES*8 | Pipelined read data |
| rvalid | output | 1 | Read data valid on this cycle |

## Verification
The assertions rely on the control inputs being settled, known levels at every rising edge once reset is released. They also assume the address is only relevant on strobe cycles, so its upper bits may change freely between strobes. The stimulus changes inputs only on falling edges and never leaves an input undriven. Random cycles are weighted towards a selected part and an open burst, so that steps, holds, wraps and the lane combinations occur often. Directed sequences cover each selection combination and both strobes low together.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
    localparam int BEAT_W = 2;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/sbsram_decode.sv
module sbsram_decode
    import sbsram_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             strobe_proc_n,
    input  logic             strobe_ctrl_n,
    input  logic             advance_n,
    input  logic             sel_a_n,
    input  logic             sel_b_n,
    input  logic             sel_c,
    input  logic             all_wr_n,
    input  logic             lane_wr_en_n,
    input  logic [LANES-1:0] lane_n,
    input  logic             active,
    output logic             load,
    output logic             desel,
    output logic             step,
    output logic [LANES-1:0] wmask,
    output acc_kind_e        kind
);
    logic selected, ctrl, proc, cont, wr_ok;
    logic [LANES-1:0] lanes_req;

    always_comb begin
        selected  = !sel_a_n && !sel_b_n && sel_c;
        ctrl      = !strobe_ctrl_n;
        proc      = !strobe_proc_n && !ctrl;
        load      = selected && (ctrl || proc);
        desel     = ctrl && !selected;
        cont      = !ctrl && !(proc && selected) && active;
        step      = cont && !advance_n;
        wr_ok     = (ctrl && selected && advance_n) || cont;
        if (!all_wr_n)
            lanes_req = '1;
        else if (!lane_wr_en_n)
            lanes_req = ~lane_n;
        else
            lanes_req = '0;
        wmask = wr_ok ? lanes_req : '0;
        if (|wmask)
            kind = ACC_WRITE;
        else if (load || cont)
            kind = ACC_READ;
        else
            kind = ACC_NONE;
    end
endmodule

// File: rtl/sbsram_lanes.sv
module sbsram_lanes #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                      clk,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES-1:0]          wmask,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output logic [LANES*LANE_W-1:0]   rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (wmask[g])
                store[addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = store[addr];
    end
endmodule

// File: rtl/sburst_sram.sv
module sburst_sram
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    strobe_proc_n,
    input  logic                    strobe_ctrl_n,
    input  logic                    advance_n,
    input  logic                    sel_a_n,
    input  logic                    sel_b_n,
    input  logic                    sel_c,
    input  logic                    all_wr_n,
    input  logic                    lane_wr_en_n,
    input  logic [LANES-1:0]        lane_n,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rvalid
);
    localparam int DATA_W = LANES * LANE_W;
    localparam int UP_W   = ADDR_W - BEAT_W;

    typedef struct packed {
        logic              active;
        logic [UP_W-1:0]   upper;
        logic [BEAT_W-1:0] cnt;
        logic              rd;
        logic [DATA_W-1:0] rdata;
    } state_t;

    state_t            st_q, st_d;
    logic              load, desel, step;
    logic [LANES-1:0]  wmask;
    acc_kind_e         kind;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] mem_rd;
    logic [BEAT_W-1:0] cnt_next;

    sbsram_decode #(.LANES(LANES)) u_decode (
        .strobe_proc_n (strobe_proc_n),
        .strobe_ctrl_n (strobe_ctrl_n),
        .advance_n     (advance_n),
        .sel_a_n       (sel_a_n),
        .sel_b_n       (sel_b_n),
        .sel_c         (sel_c),
        .all_wr_n      (all_wr_n),
        .lane_wr_en_n  (lane_wr_en_n),
        .lane_n        (lane_n),
        .active        (st_q.active),
        .load          (load),
        .desel         (desel),
        .step          (step),
        .wmask         (wmask),
        .kind          (kind)
    );

    sbsram_lanes #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_lanes (
        .clk   (clk),
        .addr  (acc_addr),
        .wmask (wmask),
        .wdata (wdata),
        .rdata (mem_rd)
    );

    always_comb begin
        st_d     = st_q;
        cnt_next = step ? st_q.cnt + 1'b1 : st_q.cnt;
        acc_addr = load ? addr : {st_q.upper, cnt_next};
        if (load) begin
            st_d.active = 1'b1;
            st_d.upper  = addr[ADDR_W-1:BEAT_W];
            st_d.cnt    = addr[BEAT_W-1:0];
        end else begin
            st_d.cnt = cnt_next;
            if (desel)
                st_d.active = 1'b0;
        end
        st_d.rd    = (kind == ACC_READ);
        st_d.rdata = (kind == ACC_READ) ? mem_rd : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rvalid = st_q.rd && !oe_n;
    assign rdata  = rvalid ? st_q.rdata : '0;
endmodule

// File: rtl/sburst_sram_chk.sv
module sburst_sram_chk #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strobe_proc_n,
    input logic              strobe_ctrl_n,
    input logic              advance_n,
    input logic              sel_a_n,
    input logic              sel_b_n,
    input logic              sel_c,
    input logic              all_wr_n,
    input logic              oe_n,
    input logic              rvalid,
    input logic [LANES-1:0]  wmask,
    input logic [ADDR_W-1:0] acc_addr
);
    logic sel_ok;
    logic past_ok;

    assign sel_ok = !sel_a_n && !sel_b_n && sel_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            past_ok <= 1'b0;
        else
            past_ok <= 1'b1;
    end

    p_oe_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> !oe_n);

    p_write_kills_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|wmask) |=> !rvalid);

    p_proc_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_proc_n && strobe_ctrl_n && sel_ok) |-> (wmask == '0));

    p_global_all_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_ctrl_n && sel_ok && advance_n && !all_wr_n) |-> (&wmask));

    p_ctrl_adv_low_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_ctrl_n && !advance_n) |-> (wmask == '0));

    p_upper_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && strobe_ctrl_n && strobe_proc_n)
        |-> (acc_addr[ADDR_W-1:2] == $past(acc_addr[ADDR_W-1:2])));

    p_deselect_ends_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_ctrl_n && !sel_ok)
        |=> (!(strobe_ctrl_n && strobe_proc_n) || (wmask == '0)));
endmodule

bind sburst_sram sburst_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .strobe_proc_n (strobe_proc_n),
    .strobe_ctrl_n (strobe_ctrl_n),
    .advance_n     (advance_n),
    .sel_a_n       (sel_a_n),
    .sel_b_n       (sel_b_n),
    .sel_c         (sel_c),
    .all_wr_n      (all_wr_n),
    .oe_n          (oe_n),
    .rvalid        (rvalid),
    .wmask         (wmask),
    .acc_addr      (acc_addr)
);

// File: tb/test_sburst_sram.sv
module test_sburst_sram;
    localparam int AW = 8;
    localparam int NL = 4;
    localparam int DW = NL * 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          strobe_proc_n = 1'b1, strobe_ctrl_n = 1'b1, advance_n = 1'b1;
    logic          sel_a_n = 1'b0, sel_b_n = 1'b0, sel_c = 1'b1;
    logic          all_wr_n = 1'b1, lane_wr_en_n = 1'b1, oe_n = 1'b0;
    logic [NL-1:0] lane_n = '1;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rvalid;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    string cur_tag = "R11";

    logic [DW-1:0] ref_mem [DEPTH];
    logic          m_act;
    logic [AW-3:0] m_up;
    logic [1:0]    m_cnt;
    logic          e_rd;
    logic [DW-1:0] e_data;

    always #5 clk = ~clk;

    sburst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(8)) i_sburst_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .strobe_proc_n(strobe_proc_n), .strobe_ctrl_n(strobe_ctrl_n),
        .advance_n(advance_n), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n),
        .sel_c(sel_c), .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n),
        .lane_n(lane_n), .oe_n(oe_n), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid)
    );

    task automatic check(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // expected behaviour from the requirements, applied to the inputs of this cycle
    task automatic model_step();
        logic sel, ctrl, proc, load, desel, cont, wr_ok, wrote;
        logic [1:0] c;
        logic [AW-1:0] a;
        logic [NL-1:0] m;
        sel   = !sel_a_n && !sel_b_n && sel_c;               // R1
        ctrl  = !strobe_ctrl_n;                              // R9
        proc  = !strobe_proc_n && !ctrl;
        load  = sel && (ctrl || proc);                       // R10
        desel = ctrl && !sel;
        cont  = !ctrl && !(proc && sel) && m_act;            // R11
        c     = !advance_n ? m_cnt + 2'd1 : m_cnt;           // R6 R7
        a     = load ? addr : {m_up, c};
        wr_ok = (ctrl && sel && advance_n) || cont;          // R4 R5
        m = !all_wr_n ? '1 : (!lane_wr_en_n ? ~lane_n : '0); // R2 R3
        if (!wr_ok) m = '0;
        wrote = |m;
        e_rd   = (load || cont) && !wrote;                   // R8
        e_data = e_rd ? ref_mem[a] : '0;
        for (int k = 0; k < NL; k++)
            if (m[k]) ref_mem[a][k*8 +: 8] = wdata[k*8 +: 8];
        if (load) begin
            m_act = 1'b1; m_up = addr[AW-1:2]; m_cnt = addr[1:0];
        end else begin
            if (cont) m_cnt = c;
            if (desel) m_act = 1'b0;
        end
    endtask

    task automatic cyc(logic sp, logic sc, logic adv, logic gw, logic bwe,
                       logic [NL-1:0] bw, logic [AW-1:0] ad, logic [DW-1:0] wd);
        strobe_proc_n = sp; strobe_ctrl_n = sc; advance_n = adv;
        all_wr_n = gw; lane_wr_en_n = bwe; lane_n = bw; addr = ad; wdata = wd;
        model_step();
        @(posedge clk);
        @(negedge clk);
        check({cur_tag, " rvalid"}, {{(DW-1){1'b0}}, rvalid}, {{(DW-1){1'b0}}, e_rd && !oe_n});
        check({cur_tag, " rdata"}, rdata, (e_rd && !oe_n) ? e_data : '0);
    endtask

    task automatic sel_on();
        sel_a_n = 1'b0; sel_b_n = 1'b0; sel_c = 1'b1;
    endtask

    // open a read at ad and show it on the following cycle
    task automatic readback(logic [AW-1:0] ad);
        sel_on();
        oe_n = 1'b0;
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, '1, ad, '0);
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '1, ad, '0);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_act = 1'b0; m_up = '0; m_cnt = '0; e_rd = 1'b0; e_data = '0;
        repeat (3) @(negedge clk);
        // R11: reset state
        cur_tag = "R11";
        check("R11 rvalid", {{(DW-1){1'b0}}, rvalid}, '0);
        check("R11 rdata", rdata, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // fill the array with single controller-strobe writes
        cur_tag = "R5";
        for (int i = 0; i < DEPTH; i++)
            cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, '1, AW'(i), DW'(32'h5A00_0000 ^ (i * 32'h0101_0107)));

        // R11: after a fresh reset, no write without a strobe
        cur_tag = "R11";
        rst_n = 1'b0;
        m_act = 1'b0; m_cnt = '0; m_up = '0; e_rd = 1'b0;
        @(negedge clk);
        check("R11 rvalid after reset", {{(DW-1){1'b0}}, rvalid}, '0);
        rst_n = 1'b1;
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, '1, 8'h00, 32'hDEAD_BEEF);
        readback(8'h00);

        // R2: global write overrides lane strobes
        cur_tag = "R2";
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, '1, 8'h10, 32'h1122_3344);
        readback(8'h10);

        // R3: per-lane writes and a blocked lane write
        cur_tag = "R3";
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'b1010, 8'h11, 32'hAABB_CCDD);
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'b0000, 8'h12, 32'hAABB_CCDD);
        readback(8'h11);
        readback(8'h12);

        // R4: processor strobe start writes nothing, next beat writes
        cur_tag = "R4";
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 4'b0000, 8'h20, 32'hFFFF_0000);
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '1, 8'h00, 32'h0BAD_F00D);
        readback(8'h20);
        readback(8'h21);

        // R5: controller strobe with advance low writes nothing
        cur_tag = "R5";
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, '1, 8'h30, 32'h0000_1111);
        readback(8'h30);

        // R6: four-beat burst wrapping within the group of four
        cur_tag = "R6";
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, '1, 8'h42, 32'h4242_0002);
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '1, 8'hFF, 32'h4242_0003);
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '1, 8'hFF, 32'h4242_0000);
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '1, 8'hFF, 32'h4242_0001);
        for (int i = 0; i < 4; i++) readback(8'h40 + 8'(i));

        // R7: suspended burst repeats the same word
        cur_tag = "R7";
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, '1, 8'h50, 32'h7000_0001);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, '1, 8'h50, 32'h7000_0002);
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '1, 8'h50, 32'h7000_0003);
        readback(8'h50);
        readback(8'h51);

        // R9: both strobes low, controller rules win (write happens)
        cur_tag = "R9";
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, '1, 8'h60, 32'h9999_0060);
        readback(8'h60);

        // R10: deselected processor strobe does not break the burst
        cur_tag = "R10";
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, '1, 8'h70, 32'hA0A0_0070);
        sel_c = 1'b0;
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, '1, 8'h90, 32'hA0A0_0071);
        readback(8'h71);
        readback(8'h90);

        // R1: each deselect combination on a controller strobe ends the burst
        cur_tag = "R1";
        for (int v = 0; v < 3; v++) begin
            cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, '1, 8'h80, 32'hC1C1_0000 + v);
            sel_on();
            if (v == 0) sel_a_n = 1'b1;
            if (v == 1) sel_b_n = 1'b1;
            if (v == 2) sel_c = 1'b0;
            cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, '1, 8'h84, 32'hBAD0_0000);
            sel_on();
            cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '1, 8'h00, 32'hBAD1_0000);
            readback(8'h81);
            readback(8'h84);
        end

        // R8: output enable high hides a valid read
        cur_tag = "R8";
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, '1, 8'h10, '0);
        oe_n = 1'b1;
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '1, 8'h10, '0);
        oe_n = 1'b0;
        cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '1, 8'h10, '0);

        // random mix
        cur_tag = "R8";
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] r;
            r = 4'($urandom_range(0, 15));
            sel_a_n = (r == 0);
            sel_b_n = (r == 1);
            sel_c   = (r != 2);
            oe_n    = ($urandom_range(0, 7) == 0);
            cyc($urandom_range(0, 5) == 0 ? 1'b0 : 1'b1,
                $urandom_range(0, 5) == 0 ? 1'b0 : 1'b1,
                1'($urandom_range(0, 1)),
                $urandom_range(0, 3) == 0 ? 1'b0 : 1'b1,
                1'($urandom_range(0, 1)),
                4'($urandom_range(0, 15)),
                AW'($urandom_range(0, DEPTH - 1)),
                DW'($urandom));
        end
        sel_on();
        oe_n = 1'b0;
        for (int i = 0; i < DEPTH; i++) readback(AW'(i));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule